// File: doc/BRIEF.md
# Interrupt Status and Clear-on-Read Unit

This unit gathers the event sources of a queued two-wire serial bus controller into one status word. Ten of the twelve sources are sticky: a single-cycle pulse from the bus engine or the queue logic sets a bit, and the bit stays set until software reads a clear address. The other two sources are levels. They are derived every cycle by comparing the transmit and receive queue fill counts against programmable thresholds, so they follow the queues and cannot be cleared.

A mask register selects which status bits drive the single interrupt line. Software uses a small register port with a read strobe and a write strobe. Clearing is done by reading, never by writing. One address clears every sticky source at once. A block of per-source addresses clears one bit each. Every clear address returns zero when read.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, every sticky bit and the mask read as 0, both thresholds read as 0 and `irq` is low, so the raw word reads 0x010 while `tx_level` and `rx_level` are 0.
- R2: A one-cycle pulse on `evt_i[k]` for a sticky source sets raw bit k from the next cycle on, and the bit holds until it is cleared by a read.
- R3: The raw word has this bit layout: 11 general call, 10 start/restart, 9 stop, 8 activity, 7 slave read done, 6 transmit abort, 5 read request, 4 transmit threshold (level), 3 transmit overflow, 2 receive threshold (level), 1 receive overflow, 0 receive underflow. Pulses on `evt_i[4]` and `evt_i[2]` are ignored.
- R4: The masked word (address 0x00) equals the raw word (address 0x01) ANDed with the mask (address 0x02, read/write). `irq` is the OR of the masked bits, so a mask of 0 keeps `irq` low.
- R5: Reading address 0x05 clears every sticky bit and returns 0.
- R6: Reading address 0x10+k clears only sticky bit k and returns 0. All other bits keep their values.
- R7: Raw bit 4 is 1 exactly while `tx_level` is at or below the transmit threshold (address 0x03, read/write).
- R8: Raw bit 2 is 1 exactly while `rx_level` is greater than the receive threshold (address 0x04, read/write). A threshold of N-1 therefore fires once N entries are present.
- R9: Clear reads do not change the two threshold bits. Reading 0x12 or 0x14 returns 0 and changes nothing.
- R10: When a pulse on a source arrives in the same cycle as a read that clears that source, the source ends up set.
- R11: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and then holds its value until the next read. A read of the raw word returns the value from before any clear applied on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Event pulses, one per source bit |
| tx_level | input | LVL_W | Transmit queue fill count |
| rx_level | input | LVL_W | Receive queue fill count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt line, the OR of the masked status |

## Verification
The bench uses the default build: a queue depth of 16 (so `LVL_W` is 5), 5-bit addresses and 16-bit data. With these values the full per-source clear block 0x10 to 0x1B fits in the address space. The thresholds can be set both just below and just above a small fill count, which lets the bench test the equality edge of the transmit comparison and the strict edge of the receive comparison. Twelve sources fit within the data width, so the bench can read the whole raw and masked words in a single access.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 12;

  localparam int B_RX_UNDER  = 0;
  localparam int B_RX_OVER   = 1;
  localparam int B_RX_THRESH = 2;
  localparam int B_TX_OVER   = 3;
  localparam int B_TX_THRESH = 4;
  localparam int B_RD_REQ    = 5;
  localparam int B_TX_ABORT  = 6;
  localparam int B_RD_DONE   = 7;
  localparam int B_ACTIVITY  = 8;
  localparam int B_STOP      = 9;
  localparam int B_START     = 10;
  localparam int B_GEN_CALL  = 11;

  localparam logic [NSRC-1:0] LEVEL_BITS =
    NSRC'((1 << B_RX_THRESH) | (1 << B_TX_THRESH));
  localparam logic [NSRC-1:0] STICKY_BITS = ~LEVEL_BITS;

  localparam int A_MASKED   = 5'h00;
  localparam int A_RAW      = 5'h01;
  localparam int A_MASK     = 5'h02;
  localparam int A_TX_THR   = 5'h03;
  localparam int A_RX_THR   = 5'h04;
  localparam int A_CLR_ALL  = 5'h05;
  localparam int A_CLR_BASE = 5'h10;

  localparam int CMP_W = 16;

  // Transmit threshold: active while the queue is at or below the level.
  function automatic logic tx_low(input logic [CMP_W-1:0] lvl,
                                  input logic [CMP_W-1:0] thr);
    return lvl <= thr;
  endfunction

  // Receive threshold: active once the queue holds more than the level.
  function automatic logic rx_high(input logic [CMP_W-1:0] lvl,
                                   input logic [CMP_W-1:0] thr);
    return lvl > thr;
  endfunction

  function automatic int clr_addr(input int src);
    return A_CLR_BASE + src;
  endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // a new event beats a clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
    end else begin : g_level
      assign q_o[i] = 1'b0;
    end
  end

  logic unused_lvl;
  assign unused_lvl = ^(set_i & LEVEL_BITS[N-1:0]) ^ ^(clr_i & LEVEL_BITS[N-1:0]);
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
  import irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  output logic             tx_hit,
  output logic             rx_hit
);
  assign tx_hit = tx_low(CMP_W'(tx_level), CMP_W'(tx_thr));
  assign rx_hit = rx_high(CMP_W'(rx_level), CMP_W'(rx_thr));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 5,
  parameter int N      = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      mask_o,
  output logic [LVL_W-1:0]  tx_thr_o,
  output logic [LVL_W-1:0]  rx_thr_o,
  output logic [N-1:0]      clr_o,
  output logic              clr_all_o,
  output logic              clr_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0] one_hit;
  logic         all_hit;

  assign all_hit = rd_i && (addr_i == ADDR_W'(A_CLR_ALL));

  for (genvar i = 0; i < N; i++) begin : g_clr
    if (STICKY_BITS[i]) begin : g_on
      assign one_hit[i] = rd_i && (addr_i == ADDR_W'(clr_addr(i)));
    end else begin : g_off
      assign one_hit[i] = 1'b0;
    end
  end

  assign clr_o     = one_hit | ({N{all_hit}} & STICKY_BITS[N-1:0]);
  assign clr_all_o = all_hit;
  assign clr_rd_o  = all_hit | (rd_i && (addr_i >= ADDR_W'(A_CLR_BASE))
                                     && (addr_i <  ADDR_W'(A_CLR_BASE + N)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= '0;
      tx_thr_o <= '0;
      rx_thr_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_W'(A_MASK):   mask_o   <= wdata_i[N-1:0];
        ADDR_W'(A_TX_THR): tx_thr_o <= wdata_i[LVL_W-1:0];
        ADDR_W'(A_RX_THR): rx_thr_o <= wdata_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_MASKED): rd_mux = DATA_W'(raw_i & mask_o);
      ADDR_W'(A_RAW):    rd_mux = DATA_W'(raw_i);
      ADDR_W'(A_MASK):   rd_mux = DATA_W'(mask_o);
      ADDR_W'(A_TX_THR): rd_mux = DATA_W'(tx_thr_o);
      ADDR_W'(A_RX_THR): rd_mux = DATA_W'(rx_thr_o);
      default:           rd_mux = '0;  // clear addresses read as zero
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  logic unused_wd;
  assign unused_wd = ^wdata_i;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int Q_DEPTH = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  localparam int LVL_W  = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NSRC-1:0]  sticky_vec;
  logic [NSRC-1:0]  raw_vec;
  logic [NSRC-1:0]  mask_vec;
  logic [NSRC-1:0]  clr_vec;
  logic [NSRC-1:0]  set_vec;
  logic             clr_all_hit;
  logic             clr_read_hit;
  logic [LVL_W-1:0] tx_thr_q;
  logic [LVL_W-1:0] rx_thr_q;
  logic             tx_hit;
  logic             rx_hit;

  assign set_vec = evt_i & STICKY_BITS;

  irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .raw_i(raw_vec), .mask_o(mask_vec),
    .tx_thr_o(tx_thr_q), .rx_thr_o(rx_thr_q), .clr_o(clr_vec),
    .clr_all_o(clr_all_hit), .clr_rd_o(clr_read_hit), .rdata_o(reg_rdata)
  );

  irq_latch_bank #(.N(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(sticky_vec)
  );

  irq_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .tx_hit(tx_hit), .rx_hit(rx_hit)
  );

  always_comb begin
    raw_vec              = sticky_vec;
    raw_vec[B_TX_THRESH] = tx_hit;
    raw_vec[B_RX_THRESH] = rx_hit;
  end

  assign irq = |(raw_vec & mask_vec);
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker
  import irq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_i,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  tx_thr_q,
  input logic [LVL_W-1:0]  rx_thr_q,
  input logic              reg_rd,
  input logic [NSRC-1:0]   raw_vec,
  input logic [NSRC-1:0]   mask_vec,
  input logic [NSRC-1:0]   clr_vec,
  input logic              clr_all_hit,
  input logic              clr_read_hit,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & STICKY_BITS)) |=> ((raw_vec & $past(evt_i & STICKY_BITS)) == $past(evt_i & STICKY_BITS))); // R10
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> ((raw_vec & $past(raw_vec & STICKY_BITS)) == $past(raw_vec & STICKY_BITS))); // R2
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '0) |-> !irq); // R4
  AST_CLEAR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_hit && (evt_i == '0)) |=> ((raw_vec & STICKY_BITS) == '0)); // R5
  AST_CLEAR_ONE_SPARES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !clr_all_hit) |=> ((raw_vec & $past(raw_vec & STICKY_BITS & ~clr_vec)) == $past(raw_vec & STICKY_BITS & ~clr_vec))); // R6
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_read_hit |=> (reg_rdata == '0)); // R5
  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vec[B_TX_THRESH] == (tx_level <= tx_thr_q)); // R7
  AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vec[B_RX_THRESH] == (rx_level > rx_thr_q)); // R8
endmodule

bind irq_status_unit irq_status_checker #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .tx_level(tx_level), .rx_level(rx_level),
  .tx_thr_q(tx_thr_q), .rx_thr_q(rx_thr_q), .reg_rd(reg_rd), .raw_vec(raw_vec),
  .mask_vec(mask_vec), .clr_vec(clr_vec), .clr_all_hit(clr_all_hit),
  .clr_read_hit(clr_read_hit), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_i = '0;
  logic [4:0]  tx_level = '0;
  logic [4:0]  rx_level = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [11:0] exp_sticky = '0;
  logic [4:0]  exp_txthr = '0;
  logic [4:0]  exp_rxthr = '0;

  always #4 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .tx_level(tx_level), .rx_level(rx_level),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [15:0] model_raw();
    logic [11:0] r;
    r = exp_sticky & 12'hFEB;
    r[4] = (tx_level <= exp_txthr);
    r[2] = (rx_level > exp_rxthr);
    return {4'h0, r};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(5'h01, d); check("R1 raw", d, 16'h0010);
    rd(5'h02, d); check("R1 mask", d, 16'h0000);
    rd(5'h03, d); check("R1 txthr", d, 16'h0000);
    rd(5'h00, d); check("R1 masked", d, 16'h0000);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    pulse(12'hFFF);                 // level positions 2 and 4 must be ignored
    exp_sticky = 12'hFEB;
    rd(5'h01, d); check("R2/R3 raw after all pulses", d, model_raw());
    repeat (3) @(negedge clk);
    rd(5'h01, d); check("R2 sticky holds", d, 16'h0FFB);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(5'h02, 16'h0041);
    rd(5'h00, d); check("R4 masked", d, 16'h0041);
    check("R4 irq on", {15'd0, irq}, 16'd1);
    wr(5'h02, 16'h0000);
    check("R4 irq silenced", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_clear_one();
    logic [15:0] d;
    rd(5'h15, d); check("R6 clear read value", d, 16'h0000);
    exp_sticky[5] = 1'b0;
    rd(5'h01, d); check("R6 only bit5 cleared", d, model_raw());
    rd(5'h1B, d);
    exp_sticky[11] = 1'b0;
    rd(5'h01, d); check("R6 only bit11 cleared", d, model_raw());
  endtask

  task automatic t_level_addr();
    logic [15:0] d;
    rd(5'h12, d); check("R9 0x12 reads 0", d, 16'h0000);
    rd(5'h14, d); check("R9 0x14 reads 0", d, 16'h0000);
    rd(5'h01, d); check("R9 raw unchanged", d, model_raw());
  endtask

  task automatic t_clear_all();
    logic [15:0] d;
    rd(5'h05, d); check("R5 clear-all read value", d, 16'h0000);
    exp_sticky = '0;
    rd(5'h01, d); check("R5 sticky bits cleared", d, 16'h0010);
  endtask

  task automatic t_tx_thr();
    logic [15:0] d;
    wr(5'h03, 16'h0003); exp_txthr = 5'd3;
    rd(5'h03, d); check("R7 threshold readback", d, 16'h0003);
    tx_level = 5'd3;
    rd(5'h01, d); check("R7 equal level", d, 16'h0010);
    tx_level = 5'd4;
    rd(5'h01, d); check("R7 above level", d, 16'h0000);
    tx_level = 5'd0;
    wr(5'h02, 16'h0010);
    check("R7 irq from tx level", {15'd0, irq}, 16'd1);
    wr(5'h02, 16'h0000);
  endtask

  task automatic t_rx_thr();
    logic [15:0] d;
    wr(5'h04, 16'h0001); exp_rxthr = 5'd1;
    rx_level = 5'd1;
    rd(5'h01, d); check("R8 level at threshold", d, model_raw());
    check("R8 bit2 off", {15'd0, d[2]}, 16'd0);
    rx_level = 5'd2;
    rd(5'h01, d); check("R8 level above", d, 16'h0014);
    rd(5'h05, d);
    rd(5'h01, d); check("R9 levels survive clear-all", d, 16'h0014);
    rx_level = 5'd0;
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    pulse(12'h200); exp_sticky[9] = 1'b1;
    @(negedge clk); evt_i = 12'h200; reg_rd = 1'b1; reg_addr = 5'h19;
    @(negedge clk); evt_i = '0; reg_rd = 1'b0;
    rd(5'h01, d); check("R10 set beats clear", d, model_raw());
  endtask

  task automatic t_rdata_hold();
    logic [15:0] d;
    rd(5'h01, d);
    check("R11 raw read", d, model_raw());
    rd(5'h05, d); check("R11 clear read 0", d, 16'h0000);
    exp_sticky = '0;
    rd(5'h01, d);
    pulse(12'h001);
    repeat (2) @(negedge clk);
    check("R11 rdata holds without read", reg_rdata, d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_mask();
    t_clear_one();
    t_level_addr();
    t_clear_all();
    t_tx_thr();
    t_rx_thr();
    t_set_wins();
    t_rdata_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule